// File: doc/BRIEF.md
# Multi-Profile SPI Master with Frame Counter

This block is an SPI master that shifts one frame for each command it accepts. Each command carries the outgoing data word, a selector naming one of six stored transfer profiles, and a flag that zeroes the frame counter. A profile fixes the frame length, SCK polarity, SCK phase, bit order and SCK rate. The profile is read when the command is accepted, so one queue can mix frames of different shapes. A single active-low chip select frames each transfer. The received word leaves on a result port as soon as the frame ends.

Software reaches the block through a small register port. Address 0 holds a 16-bit count of finished frames. Addresses 1 to 6 hold the six profiles. Register writes are accepted only while the engine is idle.

Commands use a valid/ready handshake. The transmitting side may hold `cmd_valid` for as long as it likes. `cmd_ready` is high only while no frame is in flight, so the engine itself applies back-pressure. The result port has no back-pressure: `rx_valid` is a one-cycle pulse, and the consumer must take `rx_data` in that cycle.

Top module: `spi_attr_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `cmd_ready` is 1, and every register reads as zero.
- R2: Addresses 1 to 6 hold profiles 0 to 5. The profile word layout is: bits [3:0] size code, bit 4 idle SCK level (CPOL), bit 5 phase (CPHA), bit 6 LSB-first, bits [11:8] divider code. All other bits read as 0. A selector value of 6 or 7 uses profile 5.
- R3: A size code n of 3 or more gives a frame of n+1 bits. Codes 0, 1 and 2 give 4 bits. Only the low bits of `cmd_data` are sent.
- R4: With LSB-first clear, bit N-1 of the data is sent first. With LSB-first set, bit 0 is sent first.
- R5: With divider code d, each SCK half-period lasts d+1 clocks. `cs_n` falls d+1 clocks before the first SCK edge and rises d+1 clocks after the last one. A frame has exactly 2N SCK edges. SCK rests at the CPOL level outside a frame.
- R6: With CPHA 0, a data bit is valid before the leading edge, is sampled on the leading edge, and changes on the trailing edge. With CPHA 1, a bit changes on the leading edge and is sampled on the trailing edge.
- R7: `rx_valid` pulses for one cycle, on the same clock edge on which `cs_n` rises. `rx_data` holds the N received bits, right-justified, in data order. With LSB-first set, the first bit received lands in bit 0.
- R8: The frame counter increments on the last SCK edge of every frame. It wraps from 65535 to 0.
- R9: The frame counter reads in bits [31:16] of address 0, with bits [15:0] reading 0. A write to address 0 while idle loads it from `reg_wdata[31:16]`.
- R10: A command with `cmd_clr` set zeroes the counter when it is accepted. The frame's own increment then follows, so the counter ends that frame at 1.
- R11: Register writes while a frame is in flight (`cmd_ready` low) change neither the counter nor any profile.
- R12: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. After acceptance `cmd_ready` stays low until the frame ends. If a profile write and a command acceptance fall in the same cycle, that frame uses the profile's old value.
- R13: If a counter write and a command acceptance fall in the same cycle, a set `cmd_clr` wins and the counter is zeroed. Without the flag, the written value is loaded and the frame then increments it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 counter, 1..6 profiles |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, able to take a command |
| cmd_data | input | 16 | Word to transmit |
| cmd_sel | input | 3 | Profile selector |
| cmd_clr | input | 1 | Zero the frame counter at frame start |
| rx_valid | output | 1 | One-cycle pulse: received word available |
| rx_data | output | 16 | Received word, right-justified |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
Only one frame is ever in flight, so the register port and the command port can collide only in the idle cycle in which a command is accepted. The bench provokes that collision twice: once by driving a profile write to the selected profile together with the command, and once by driving a counter write together with the command, both with and without the clear flag. It judges the profile case by counting SCK edges and captured bits, which must match the old frame length, and then running a second frame that must match the new one. It judges the counter case by reading the counter back after the frame: the written value plus one without the flag, and 1 with it.

// File: rtl/spi_attr_pkg.sv
package spi_attr_pkg;

  localparam int SIZE_W = 4;
  localparam int DIV_W  = 4;

  // Per-profile transfer attributes.
  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic              lsb_first;
    logic              cpha;
    logic              cpol;
    logic [SIZE_W-1:0] size;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_HOLD  = 2'd3
  } eng_state_e;

endpackage

// File: rtl/spi_attr_regbank.sv
module spi_attr_regbank
  import spi_attr_pkg::*;
#(
  parameter int NUM_SETS = 6,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  attr_t            wr_val,
  input  logic [SEL_W-1:0] rd_idx,
  output attr_t            rd_val,
  input  logic [SEL_W-1:0] use_idx,
  output attr_t            use_val
);

  localparam int FLAT_W = NUM_SETS * ATTR_W;

  logic [FLAT_W-1:0] flat;

  generate
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
      attr_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (wr_en && (wr_idx == SEL_W'(g))) begin
          q <= wr_val;
        end
      end
      assign flat[g*ATTR_W +: ATTR_W] = q;
    end
  endgenerate

  // Out-of-range read index returns zero.
  always_comb begin
    rd_val = '0;
    if (int'(rd_idx) < NUM_SETS) begin
      rd_val = attr_t'(flat[int'(rd_idx)*ATTR_W +: ATTR_W]);
    end
  end

  // Out-of-range use index falls back to the highest profile.
  always_comb begin
    if (int'(use_idx) < NUM_SETS) begin
      use_val = attr_t'(flat[int'(use_idx)*ATTR_W +: ATTR_W]);
    end else begin
      use_val = attr_t'(flat[(NUM_SETS-1)*ATTR_W +: ATTR_W]);
    end
  end

endmodule

// File: rtl/spi_attr_tcount.sv
module spi_attr_tcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);

  // clr and load both happen only while idle; inc only while busy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc) begin
      count <= count + CNT_W'(1);
    end else if (load) begin
      count <= load_val;
    end
  end

endmodule

// File: rtl/spi_attr_engine.sv
module spi_attr_engine
  import spi_attr_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  attr_t             start_attr,
  input  logic [WORD_W-1:0] start_data,
  output logic              idle,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              last_edge
);

  localparam int NB_W = $clog2(WORD_W + 1);
  localparam int EC_W = NB_W + 1;

  function automatic logic [WORD_W-1:0] rev(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
    return r;
  endfunction

  function automatic logic [NB_W-1:0] frame_bits(input logic [SIZE_W-1:0] code);
    if (code < SIZE_W'(3)) return NB_W'(4);
    return NB_W'(code) + NB_W'(1);
  endfunction

  eng_state_e        st_q;
  logic [DIV_W-1:0]  hcnt_q;
  logic [EC_W-1:0]   edge_q;
  attr_t             cur_q;
  logic [NB_W-1:0]   nb_q;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic              sck_q;
  logic              cs_q;
  logic              rxv_q;
  logic [WORD_W-1:0] rxd_q;

  logic              tick;
  logic              edge_ev;
  logic              lead;
  logic              samp;
  logic              shft;
  logic              fin_edge;
  logic [NB_W-1:0]   nb_start;
  logic [WORD_W-1:0] tx_start;
  logic [WORD_W-1:0] rx_word;

  assign tick     = (hcnt_q == '0);
  assign edge_ev  = ((st_q == ST_SETUP) || (st_q == ST_SHIFT)) && tick;
  assign lead     = ~edge_q[0];
  assign samp     = cur_q.cpha ? ~lead : lead;
  assign shft     = cur_q.cpha ? (lead && (edge_q != '0)) : ~lead;
  assign fin_edge = edge_ev && (edge_q == ({nb_q, 1'b0} - EC_W'(1)));

  // Place the first bit to send in the top bit of the shift register.
  always_comb begin
    nb_start = frame_bits(start_attr.size);
    if (start_attr.lsb_first) begin
      tx_start = rev(start_data);
    end else begin
      tx_start = start_data << (WORD_W - int'(nb_start));
    end
  end

  // Right-justify received bits in data order.
  always_comb begin
    if (cur_q.lsb_first) begin
      rx_word = rev(rx_q) >> (WORD_W - int'(nb_q));
    end else begin
      rx_word = rx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hcnt_q <= '0;
      edge_q <= '0;
      cur_q  <= '0;
      nb_q   <= NB_W'(4);
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      rxv_q  <= 1'b0;
      rxd_q  <= '0;
    end else begin
      rxv_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            cur_q  <= start_attr;
            nb_q   <= nb_start;
            tx_q   <= tx_start;
            rx_q   <= '0;
            hcnt_q <= start_attr.div;
            edge_q <= '0;
            sck_q  <= start_attr.cpol;
            cs_q   <= 1'b0;
            st_q   <= ST_SETUP;
          end
        end
        ST_SETUP, ST_SHIFT: begin
          if (tick) begin
            sck_q  <= ~sck_q;
            hcnt_q <= cur_q.div;
            edge_q <= edge_q + EC_W'(1);
            if (samp) rx_q <= {rx_q[WORD_W-2:0], miso};
            if (shft) tx_q <= tx_q << 1;
            st_q <= fin_edge ? ST_HOLD : ST_SHIFT;
          end else begin
            hcnt_q <= hcnt_q - DIV_W'(1);
          end
        end
        ST_HOLD: begin
          if (tick) begin
            st_q  <= ST_IDLE;
            cs_q  <= 1'b1;
            rxv_q <= 1'b1;
            rxd_q <= rx_word;
          end else begin
            hcnt_q <= hcnt_q - DIV_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign sck       = sck_q;
  assign cs_n      = cs_q;
  assign mosi      = cs_q ? 1'b0 : tx_q[WORD_W-1];
  assign rx_valid  = rxv_q;
  assign rx_data   = rxd_q;
  assign last_edge = fin_edge;

endmodule

// File: rtl/spi_attr_master.sv
module spi_attr_master
  import spi_attr_pkg::*;
#(
  parameter int NUM_SETS = 6,
  parameter int CNT_W    = 16,
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int SEL_W    = 3,
  parameter int REG_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic              cmd_clr,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  localparam int LOW_W = REG_W - CNT_W;

  logic              idle;
  logic              start;
  logic              start_clr;
  logic              last_edge;
  logic              addr_is_cnt;
  logic              addr_is_set;
  logic              set_wr;
  logic              cnt_load;
  logic [SEL_W-1:0]  set_idx;
  attr_t             wr_attr;
  attr_t             rd_attr;
  attr_t             use_attr;
  logic [CNT_W-1:0]  cnt_q;

  assign addr_is_cnt = (reg_addr == '0);
  assign addr_is_set = (int'(reg_addr) >= 1) && (int'(reg_addr) <= NUM_SETS);
  assign set_idx     = SEL_W'(reg_addr - ADDR_W'(1));
  assign set_wr      = reg_wr && idle && addr_is_set;
  assign cnt_load    = reg_wr && idle && addr_is_cnt;
  assign start       = cmd_valid && idle;
  assign start_clr   = start && cmd_clr;
  assign cmd_ready   = idle;

  always_comb begin
    wr_attr           = '0;
    wr_attr.size      = reg_wdata[3:0];
    wr_attr.cpol      = reg_wdata[4];
    wr_attr.cpha      = reg_wdata[5];
    wr_attr.lsb_first = reg_wdata[6];
    wr_attr.div       = reg_wdata[11:8];
  end

  wire unused_wdata = ^{reg_wdata[15:12], reg_wdata[7]};

  always_comb begin
    reg_rdata = '0;
    if (addr_is_cnt) begin
      reg_rdata = {cnt_q, {LOW_W{1'b0}}};
    end else if (addr_is_set) begin
      reg_rdata = REG_W'({rd_attr.div, 1'b0, rd_attr.lsb_first, rd_attr.cpha,
                          rd_attr.cpol, rd_attr.size});
    end
  end

  spi_attr_regbank #(
    .NUM_SETS (NUM_SETS),
    .SEL_W    (SEL_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (set_wr),
    .wr_idx  (set_idx),
    .wr_val  (wr_attr),
    .rd_idx  (set_idx),
    .rd_val  (rd_attr),
    .use_idx (cmd_sel),
    .use_val (use_attr)
  );

  spi_attr_tcount #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_clr),
    .inc      (last_edge),
    .load     (cnt_load),
    .load_val (reg_wdata[REG_W-1 -: CNT_W]),
    .count    (cnt_q)
  );

  spi_attr_engine #(
    .WORD_W (WORD_W)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_attr (use_attr),
    .start_data (cmd_data),
    .idle       (idle),
    .sck        (sck),
    .mosi       (mosi),
    .cs_n       (cs_n),
    .miso       (miso),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .last_edge  (last_edge)
  );

endmodule

// File: rtl/spi_attr_master_chk.sv
module spi_attr_master_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_clr,
  input logic              cs_n,
  input logic              sck,
  input logic              rx_valid,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CNT_W-1:0]  cnt,
  input logic              last_edge
);

  // R12
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> cs_n);

  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  rx_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (cs_n && cmd_ready));

  // R5
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> $stable(sck));

  // R10
  clr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_clr) |=> (cnt == '0));

  // R8
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_edge |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R11
  busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && reg_wr && (reg_addr == '0) && !last_edge) |=> $stable(cnt));

endmodule

bind spi_attr_master spi_attr_master_chk #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_clr   (cmd_clr),
  .cs_n      (cs_n),
  .sck       (sck),
  .rx_valid  (rx_valid),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .cnt       (cnt_q),
  .last_edge (last_edge)
);

// File: tb/spi_attr_master_test.sv
module spi_attr_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = '0;
  logic [2:0]  cmd_sel = '0;
  logic        cmd_clr = 1'b0;
  logic        rx_valid;
  logic [15:0] rx_data;
  logic        sck, mosi, miso, cs_n;
  logic        inv = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign miso = inv ? ~mosi : mosi;

  spi_attr_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_sel(cmd_sel),
    .cmd_clr(cmd_clr), .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // Line monitor, sampled away from the active edge
  logic        m_cpol = 1'b0, m_cpha = 1'b0;
  int          m_div = 0;
  logic        prev_sck = 1'b0, prev_cs = 1'b1;
  logic [15:0] cap = '0;
  int          capn = 0, nedge = 0, half_bad = 0;
  int          t_cs = 0, t_last = 0, setup_c = 0, hold_c = 0;
  logic        fall_sck = 1'b0;

  always @(negedge clk) begin
    if (!cs_n && prev_cs) begin
      t_cs = cyc; fall_sck = sck; cap = '0; capn = 0; nedge = 0; half_bad = 0;
    end else if (!cs_n && !prev_cs && (sck != prev_sck)) begin
      if (nedge == 0) setup_c = cyc - t_cs;
      else if (cyc - t_last != m_div + 1) half_bad++;
      t_last = cyc;
      nedge++;
      if ((sck != m_cpol) ^ m_cpha) begin
        cap = {cap[14:0], mosi};
        capn++;
      end
    end
    if (cs_n && !prev_cs) hold_c = cyc - t_last;
    prev_cs = cs_n;
    prev_sck = sck;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] aw(input logic [3:0] code, input logic cpol,
                                     input logic cpha, input logic lsb, input logic [3:0] div);
    return {20'b0, div, 1'b0, lsb, cpha, cpol, code};
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // One full frame: push, wait, then judge the line and the result.
  task automatic frame(input string tag, input logic [2:0] sel, input logic [15:0] data,
                       input logic clr, input logic inv_in, input logic [3:0] code,
                       input logic cpol, input logic cpha, input logic lsb,
                       input logic [3:0] div, input logic [15:0] exp_cnt,
                       input logic do_wr, input logic [2:0] wa, input logic [31:0] wd);
    int n;
    logic [15:0] mask, exp_cap, exp_rx;
    logic [31:0] r;
    bit seen;
    n = (code < 3) ? 4 : int'(code) + 1;
    mask = 16'((32'd1 << n) - 1);
    exp_cap = '0;
    for (int i = 0; i < n; i++) exp_cap[n-1-i] = lsb ? data[i] : data[n-1-i];
    exp_rx = (data & mask) ^ (inv_in ? mask : 16'h0);
    m_cpol = cpol; m_cpha = cpha; m_div = int'(div); inv = inv_in;
    @(negedge clk);
    check({tag, " R12 ready before push"}, 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_data = data; cmd_clr = clr;
    if (do_wr) begin reg_wr = 1'b1; reg_addr = wa; reg_wdata = wd; end
    @(negedge clk);
    cmd_valid = 1'b0; cmd_clr = 1'b0; reg_wr = 1'b0;
    check({tag, " R12 ready low when busy"}, 32'(cmd_ready), 32'd0);
    seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (rx_valid) seen = 1;
    end
    check({tag, " R7 rx_valid seen"}, 32'(seen), 32'd1);
    check({tag, " R7 rx_data"}, 32'(rx_data), 32'(exp_rx));
    check({tag, " R7 cs_n high with rx_valid"}, 32'(cs_n), 32'd1);
    @(negedge clk);
    check({tag, " R7 rx_valid one cycle"}, 32'(rx_valid), 32'd0);
    check({tag, " R3 bit count"}, 32'(capn), 32'(n));
    check({tag, " R4 R6 bits on line"}, 32'(cap), 32'(exp_cap));
    check({tag, " R5 edge count"}, 32'(nedge), 32'(2 * n));
    check({tag, " R5 setup"}, 32'(setup_c), 32'(int'(div) + 1));
    check({tag, " R5 hold"}, 32'(hold_c), 32'(int'(div) + 1));
    check({tag, " R5 half periods"}, 32'(half_bad), 32'd0);
    check({tag, " R5 idle level at start"}, 32'(fall_sck), 32'(cpol));
    check({tag, " R5 idle level after"}, 32'(sck), 32'(cpol));
    rd_reg(3'd0, r);
    check({tag, " R8 R9 counter"}, r, {exp_cnt, 16'h0});
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 cs_n", 32'(cs_n), 32'd1);
    check("R1 sck", 32'(sck), 32'd0);
    check("R1 cmd_ready", 32'(cmd_ready), 32'd1);
    for (int a = 0; a < 7; a++) begin
      rd_reg(3'(a), r);
      check("R1 register zero", r, 32'd0);
    end
  endtask

  task automatic t_profiles();
    logic [31:0] r;
    wr_reg(3'd2, 32'hFFFF_FFFF);
    rd_reg(3'd2, r);
    check("R2 layout mask", r, 32'h0000_0F7F);
    wr_reg(3'd1, aw(4'd7, 1'b0, 1'b0, 1'b0, 4'd1));
    wr_reg(3'd2, aw(4'd7, 1'b0, 1'b0, 1'b0, 4'd0));
    wr_reg(3'd4, aw(4'd11, 1'b1, 1'b1, 1'b1, 4'd0));
    wr_reg(3'd5, aw(4'd15, 1'b1, 1'b0, 1'b1, 4'd3));
    wr_reg(3'd6, aw(4'd1, 1'b0, 1'b1, 1'b0, 4'd2));
    rd_reg(3'd4, r);
    check("R2 profile 3 readback", r, aw(4'd11, 1'b1, 1'b1, 1'b1, 4'd0));
  endtask

  task automatic t_shapes();
    frame("msb8",  3'd0, 16'h12C6, 1'b0, 1'b0, 4'd7,  1'b0, 1'b0, 1'b0, 4'd1, 16'd1, 1'b0, 3'd0, 32'd0);
    frame("lsb12", 3'd3, 16'h0A3C, 1'b0, 1'b1, 4'd11, 1'b1, 1'b1, 1'b1, 4'd0, 16'd2, 1'b0, 3'd0, 32'd0);
    frame("R2 sel7 small code", 3'd7, 16'hFFFD, 1'b0, 1'b0, 4'd1, 1'b0, 1'b1, 1'b0, 4'd2, 16'd3, 1'b0, 3'd0, 32'd0);
    frame("lsb16", 3'd4, 16'hB461, 1'b0, 1'b1, 4'd15, 1'b1, 1'b0, 1'b1, 4'd3, 16'd4, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic t_wrap();
    logic [31:0] r;
    wr_reg(3'd0, 32'hFFFF_1234);
    rd_reg(3'd0, r);
    check("R9 preset readback", r, 32'hFFFF_0000);
    frame("R8 wrap", 3'd1, 16'h0055, 1'b0, 1'b0, 4'd7, 1'b0, 1'b0, 1'b0, 4'd0, 16'd0, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic t_clear();
    wr_reg(3'd0, 32'h0100_0000);
    frame("R10 clear", 3'd1, 16'h00A9, 1'b1, 1'b1, 4'd7, 1'b0, 1'b0, 1'b0, 4'd0, 16'd1, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic t_busy();
    logic [31:0] r;
    bit seen;
    m_cpol = 1'b0; m_cpha = 1'b0; m_div = 1; inv = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = 3'd0; cmd_data = 16'h003C; cmd_clr = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h7777_0000;
    @(negedge clk);
    reg_addr = 3'd1; reg_wdata = aw(4'd3, 1'b1, 1'b1, 1'b1, 4'd9);
    @(negedge clk);
    reg_wr = 1'b0;
    seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (rx_valid) seen = 1;
    end
    check("R11 frame completes", 32'(seen), 32'd1);
    rd_reg(3'd0, r);
    check("R11 counter unchanged by busy write", r, 32'h0002_0000);
    rd_reg(3'd1, r);
    check("R11 profile unchanged by busy write", r, aw(4'd7, 1'b0, 1'b0, 1'b0, 4'd1));
  endtask

  task automatic t_collide();
    logic [31:0] r;
    frame("R13 load with accept", 3'd1, 16'h0033, 1'b0, 1'b0, 4'd7, 1'b0, 1'b0, 1'b0, 4'd0,
          16'h0041, 1'b1, 3'd0, 32'h0040_0000);
    frame("R13 clear beats load", 3'd1, 16'h00C3, 1'b1, 1'b0, 4'd7, 1'b0, 1'b0, 1'b0, 4'd0,
          16'd1, 1'b1, 3'd0, 32'h0040_0000);
    frame("R12 old profile used", 3'd1, 16'hBEEF, 1'b0, 1'b0, 4'd7, 1'b0, 1'b0, 1'b0, 4'd0,
          16'd2, 1'b1, 3'd2, aw(4'd15, 1'b0, 1'b0, 1'b0, 4'd0));
    rd_reg(3'd2, r);
    check("R12 profile updated after accept", r, aw(4'd15, 1'b0, 1'b0, 1'b0, 4'd0));
    frame("R12 new profile next", 3'd1, 16'hBEEF, 1'b0, 1'b0, 4'd15, 1'b0, 1'b0, 1'b0, 4'd0,
          16'd3, 1'b0, 3'd0, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_profiles();
    t_shapes();
    t_wrap();
    t_clear();
    t_busy();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule